// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits in front of a one-time-programmable word memory and turns a stream of synchronous bus writes into mode changes and program requests. Every command must be preceded by a two-write unlock handshake. The third write selects a command: enter identification mode, arm a single-word program, or hand off a multi-word program. A bare reset byte written to any address also returns the decoder to plain read mode. Writes only count while a high-voltage-present qualifier is asserted. A write without it aborts any partial sequence and any identification session.

The decoder shows its state as a two-bit mode: read, identify, busy or fault. It issues a one-cycle start pulse that carries the latched program address and word, or a separate one-cycle pulse that starts the multi-word engine. The program engine reports back with done and fail strobes. While the engine runs, the decoder ignores every write. After a failure it ignores everything except the reset byte. In identify mode, reads return fixed identification words one cycle after the request.

Top module: `cmd_decoder`

## Requirements
- R1: After reset, mode_o is read (2'b00), and prog_start_o, multi_start_o and id_valid_o are low.
- R2: The sequence AAh at address 555h, then 55h at 2AAh, then 90h at 555h sets mode_o to identify (2'b01). Only write address bits 10:0 and data bits 7:0 are compared, and all higher bits are don't-care.
- R3: In identify mode, a read with rd_sel_i=2'b00 gives id_data_o=0020h, and rd_sel_i=2'b01 gives 888Ah. Either result appears with id_valid_o high in the cycle after the request. Outside identify mode, id_valid_o stays low.
- R4: In identify mode, every write is ignored except one whose low data byte is F0h, which returns the mode to read.
- R5: After unlock plus A0h at 555h, the next write pulses prog_start_o for exactly one cycle. The pulse carries that write's full address on prog_addr_o and its full data on prog_word_o, and mode_o becomes busy (2'b10) in the same cycle.
- R6: After unlock plus 20h at 555h, multi_start_o pulses for one cycle and mode_o becomes busy.
- R7: A write that does not continue a valid sequence returns the decoder to its idle read state, so the next command must begin again with the full unlock.
- R8: A write with hv_ok_i low has no command effect. It aborts any partial sequence, an armed program or identify mode, and sends the decoder back to read mode without a start pulse.
- R9: While busy, all writes are ignored, including F0h. A pgm_done_i strobe returns the mode to read.
- R10: A pgm_fail_i strobe while busy sets mode_o to fault (2'b11). Fault is left only by a write of F0h with hv_ok_i high.
- R11: F0h in the third position after the two unlock writes, or F0h as a single write in the middle of a sequence, resets the decoder to idle read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hv_ok_i | input | 1 | Programming voltage present |
| wr_en_i | input | 1 | Write strobe, one cycle per bus write |
| wr_addr_i | input | 22 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 2 | Low two read address bits |
| pgm_done_i | input | 1 | Program engine finished without error |
| pgm_fail_i | input | 1 | Program engine reported a failure |
| mode_o | output | 2 | 0 read, 1 identify, 2 busy, 3 fault |
| prog_start_o | output | 1 | One-cycle single-word program request |
| prog_addr_o | output | 22 | Latched program address |
| prog_word_o | output | 16 | Latched program word |
| multi_start_o | output | 1 | One-cycle multi-word program request |
| id_valid_o | output | 1 | Identification word valid |
| id_data_o | output | 16 | Identification word |

## Verification
The bench targets sequences that almost unlock: a second write at a neighbouring address, a wrong command byte, and a reset byte dropped into the middle. A decoder that kept a stale position would later accept a lone 90h. It also tries reset and unlock writes while busy and after a failure, where a design that honours them would abort a running program. It drops the voltage qualifier on the armed fourth write, which must never give a start pulse. Finally, it writes upper address and data bits full of ones to show that only the low fields are decoded.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_ARM, SQ_IDENT, SQ_BUSY, SQ_FAULT
  } seq_e;

  localparam logic [1:0] MODE_READ  = 2'd0;
  localparam logic [1:0] MODE_IDENT = 2'd1;
  localparam logic [1:0] MODE_BUSY  = 2'd2;
  localparam logic [1:0] MODE_FAULT = 2'd3;

  localparam int CMP_AW = 11;
  localparam int CMP_DW = 8;

  localparam logic [CMP_AW-1:0] KEY1_ADDR = 11'h555;
  localparam logic [CMP_AW-1:0] KEY2_ADDR = 11'h2AA;
  localparam logic [CMP_DW-1:0] KEY1_BYTE = 8'hAA;
  localparam logic [CMP_DW-1:0] KEY2_BYTE = 8'h55;
  localparam logic [CMP_DW-1:0] OP_IDENT  = 8'h90;
  localparam logic [CMP_DW-1:0] OP_WORD   = 8'hA0;
  localparam logic [CMP_DW-1:0] OP_MULTI  = 8'h20;
  localparam logic [CMP_DW-1:0] OP_RESET  = 8'hF0;
endpackage

// File: rtl/cmd_match.sv
module cmd_match
  import cmd_pkg::*;
(
  input  logic [CMP_AW-1:0] addr_i,
  input  logic [CMP_DW-1:0] byte_i,
  output logic              key1_o,
  output logic              key2_o,
  output logic              op_ident_o,
  output logic              op_word_o,
  output logic              op_multi_o,
  output logic              rst_o
);
  logic at_cmd_addr;

  assign at_cmd_addr = (addr_i == KEY1_ADDR);
  assign key1_o      = at_cmd_addr && (byte_i == KEY1_BYTE);
  assign key2_o      = (addr_i == KEY2_ADDR) && (byte_i == KEY2_BYTE);
  assign op_ident_o  = at_cmd_addr && (byte_i == OP_IDENT);
  assign op_word_o   = at_cmd_addr && (byte_i == OP_WORD);
  assign op_multi_o  = at_cmd_addr && (byte_i == OP_MULTI);
  // reset byte is honoured at any address
  assign rst_o       = (byte_i == OP_RESET);
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              hv_ok_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              key1_i,
  input  logic              key2_i,
  input  logic              op_ident_i,
  input  logic              op_word_i,
  input  logic              op_multi_i,
  input  logic              rst_i,
  input  logic              pgm_done_i,
  input  logic              pgm_fail_i,
  output logic [1:0]        mode_o,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_word_o,
  output logic              multi_start_o
);
  seq_e state_q, state_d;
  logic start_d, multi_d;
  logic wr_ok;

  assign wr_ok = wr_en_i && hv_ok_i;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    multi_d = 1'b0;
    unique case (state_q)
      SQ_BUSY: begin
        if (pgm_fail_i)      state_d = SQ_FAULT;
        else if (pgm_done_i) state_d = SQ_IDLE;
      end
      SQ_FAULT: begin
        if (wr_ok && rst_i) state_d = SQ_IDLE;
      end
      SQ_IDENT: begin
        if (wr_en_i && (!hv_ok_i || rst_i)) state_d = SQ_IDLE;
      end
      SQ_ARM: begin
        if (wr_ok) begin
          state_d = SQ_BUSY;
          start_d = 1'b1;
        end else if (wr_en_i) begin
          state_d = SQ_IDLE;
        end
      end
      SQ_UNL2: begin
        if (wr_ok) begin
          if (op_ident_i)      state_d = SQ_IDENT;
          else if (op_word_i)  state_d = SQ_ARM;
          else if (op_multi_i) begin
            state_d = SQ_BUSY;
            multi_d = 1'b1;
          end else state_d = SQ_IDLE;
        end else if (wr_en_i) begin
          state_d = SQ_IDLE;
        end
      end
      SQ_UNL1: begin
        if (wr_en_i) state_d = (wr_ok && key2_i) ? SQ_UNL2 : SQ_IDLE;
      end
      default: begin
        if (wr_en_i) state_d = (wr_ok && key1_i) ? SQ_UNL1 : SQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= SQ_IDLE;
      prog_start_o  <= 1'b0;
      multi_start_o <= 1'b0;
      prog_addr_o   <= '0;
      prog_word_o   <= '0;
    end else begin
      state_q       <= state_d;
      prog_start_o  <= start_d;
      multi_start_o <= multi_d;
      if (start_d) begin
        prog_addr_o <= wr_addr_i;
        prog_word_o <= wr_data_i;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      SQ_IDENT: mode_o = MODE_IDENT;
      SQ_BUSY:  mode_o = MODE_BUSY;
      SQ_FAULT: mode_o = MODE_FAULT;
      default:  mode_o = MODE_READ;
    endcase
  end
endmodule

// File: rtl/id_rom.sv
module id_rom #(
  parameter int               DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0020,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h888A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ident_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_sel_i,
  output logic              id_valid_o,
  output logic [DATA_W-1:0] id_data_o
);
  logic [DATA_W-1:0] code;
  logic              hit;

  assign hit  = rd_en_i && ident_i;
  assign code = rd_sel_i[1] ? '0 : (rd_sel_i[0] ? DEV_CODE : MFR_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_valid_o <= 1'b0;
      id_data_o  <= '0;
    end else begin
      id_valid_o <= hit;
      id_data_o  <= hit ? code : '0;
    end
  end
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hv_ok_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_sel_i,
  input  logic              pgm_done_i,
  input  logic              pgm_fail_i,
  output logic [1:0]        mode_o,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_word_o,
  output logic              multi_start_o,
  output logic              id_valid_o,
  output logic [DATA_W-1:0] id_data_o
);
  logic key1, key2, op_ident, op_word, op_multi, rst_hit;
  logic [CMP_DW-1:0] cmd_byte;

  assign cmd_byte = wr_data_i[CMP_DW-1:0];

  cmd_match u_match (
    .addr_i     (wr_addr_i[CMP_AW-1:0]),
    .byte_i     (cmd_byte),
    .key1_o     (key1),
    .key2_o     (key2),
    .op_ident_o (op_ident),
    .op_word_o  (op_word),
    .op_multi_o (op_multi),
    .rst_o      (rst_hit)
  );

  cmd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .hv_ok_i       (hv_ok_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .key1_i        (key1),
    .key2_i        (key2),
    .op_ident_i    (op_ident),
    .op_word_i     (op_word),
    .op_multi_i    (op_multi),
    .rst_i         (rst_hit),
    .pgm_done_i    (pgm_done_i),
    .pgm_fail_i    (pgm_fail_i),
    .mode_o        (mode_o),
    .prog_start_o  (prog_start_o),
    .prog_addr_o   (prog_addr_o),
    .prog_word_o   (prog_word_o),
    .multi_start_o (multi_start_o)
  );

  id_rom #(.DATA_W(DATA_W)) u_id (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ident_i    (mode_o == MODE_IDENT),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (rd_sel_i),
    .id_valid_o (id_valid_o),
    .id_data_o  (id_data_o)
  );
endmodule

// File: rtl/cmd_decoder_chk.sv
module cmd_decoder_chk
  import cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hv_ok_i,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic       pgm_done_i,
  input logic       pgm_fail_i,
  input logic       rst_hit_i,
  input logic [1:0] mode_o,
  input logic       prog_start_o,
  input logic       multi_start_o,
  input logic       id_valid_o
);
  assert_start_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> mode_o == MODE_BUSY);

  assert_start_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !prog_start_o);

  assert_multi_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_start_o |-> (mode_o == MODE_BUSY && !prog_start_o));

  assert_id_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && mode_o == MODE_IDENT) |=> !id_valid_o);

  assert_id_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && mode_o == MODE_IDENT) |=> id_valid_o);

  assert_hv_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hv_ok_i && (mode_o == MODE_READ || mode_o == MODE_IDENT))
      |=> (mode_o == MODE_READ && !prog_start_o && !multi_start_o));

  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_BUSY && !pgm_done_i && !pgm_fail_i) |=> mode_o == MODE_BUSY);

  assert_fault_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_FAULT && !(wr_en_i && hv_ok_i && rst_hit_i)) |=> mode_o == MODE_FAULT);
endmodule

bind cmd_decoder cmd_decoder_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hv_ok_i       (hv_ok_i),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .pgm_done_i    (pgm_done_i),
  .pgm_fail_i    (pgm_fail_i),
  .rst_hit_i     (rst_hit),
  .mode_o        (mode_o),
  .prog_start_o  (prog_start_o),
  .multi_start_o (multi_start_o),
  .id_valid_o    (id_valid_o)
);

// File: tb/tb_cmd_decoder.sv
`timescale 1ns/1ps
module tb_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hv = 1'b1;
  logic        wr_en = 1'b0;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic        done = 1'b0;
  logic        fail = 1'b0;
  logic [1:0]  mode;
  logic        pstart, mstart, idv;
  logic [21:0] paddr;
  logic [15:0] pword, idd;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // expected item: {kind[1:0], addr[21:0], data[15:0]}; kind 0 prog, 1 multi, 2 id
  logic [39:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cmd_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .hv_ok_i(hv), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_sel_i(rd_sel), .pgm_done_i(done), .pgm_fail_i(fail),
    .mode_o(mode), .prog_start_o(pstart), .prog_addr_o(paddr),
    .prog_word_o(pword), .multi_start_o(mstart), .id_valid_o(idv),
    .id_data_o(idd)
  );

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_mode(input logic [1:0] exp, input string tag);
    chk(mode == exp, tag, {38'd0, mode}, {38'd0, exp});
  endtask

  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock(input logic [7:0] op);
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(22'h555, {8'h00, op});
  endtask

  task automatic id_read(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    exp_q.push_back({2'd2, 22'd0, exp});
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic strobe(input bit is_fail);
    @(negedge clk);
    if (is_fail) fail = 1'b1; else done = 1'b1;
    @(negedge clk);
    fail = 1'b0; done = 1'b0;
  endtask

  // monitor: every result the design produces must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && (pstart || mstart || idv)) begin
      logic [39:0] act;
      logic [39:0] exp;
      string       tg;
      if (pstart)      act = {2'd0, paddr, pword};
      else if (mstart) act = {2'd1, 22'd0, 16'd0};
      else             act = {2'd2, 22'd0, idd};
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected result", act, 40'd0);
      end else begin
        exp = exp_q.pop_front();
        tg  = tag_q.pop_front();
        chk(act == exp, tg, act, exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_mode(2'd0, "R1 reset mode");
    chk(!pstart && !mstart && !idv, "R1 pulses low", {37'd0, pstart, mstart, idv}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_mode(2'd0, "R1 mode after release");

    // read outside identify yields nothing
    @(negedge clk); rd_en = 1'b1; rd_sel = 2'b00;
    @(negedge clk); rd_en = 1'b0;
    chk(!idv, "R3 no id outside identify", {39'd0, idv}, 40'd0);

    // R2 identify entry and R3 codes
    unlock(8'h90);
    chk_mode(2'd1, "R2 identify entered");
    id_read(2'b00, 16'h0020, "R3 maker code");
    id_read(2'b01, 16'h888A, "R3 device code");

    // R4 other commands ignored in identify
    unlock(8'hA0);
    wr(22'h12, 16'h1234);
    chk_mode(2'd1, "R4 identify holds");
    wr(22'h123, 16'h55F0);
    chk_mode(2'd0, "R4 F0 leaves identify");

    // R2 upper bits are don't-care
    wr(22'h3FF555, 16'hFFAA);
    wr(22'h1522AA, 16'h1255);
    wr(22'h200555, 16'hC390);
    chk_mode(2'd1, "R2 upper bits ignored");
    wr(22'h0, 16'h00F0);
    chk_mode(2'd0, "R4 reset to read");

    // R7 broken sequences
    wr(22'h555, 16'h00AA); wr(22'h2AB, 16'h0055); wr(22'h555, 16'h0090);
    chk_mode(2'd0, "R7 wrong second address");
    unlock(8'h77);
    wr(22'h555, 16'h0090);
    chk_mode(2'd0, "R7 bad op then lone 90");

    // R11 resets inside a sequence
    wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h0055); wr(22'h7, 16'h00F0);
    wr(22'h555, 16'h0090);
    chk_mode(2'd0, "R11 third-write reset clears");
    wr(22'h555, 16'h00AA); wr(22'h9, 16'h00F0); wr(22'h2AA, 16'h0055); wr(22'h555, 16'h0090);
    chk_mode(2'd0, "R11 single reset mid sequence");

    // R8 voltage qualifier
    hv = 1'b0;
    unlock(8'h90);
    hv = 1'b1;
    chk_mode(2'd0, "R8 sequence without voltage");
    wr(22'h555, 16'h00AA);
    hv = 1'b0; wr(22'h2AA, 16'h0055); hv = 1'b1;
    wr(22'h555, 16'h0090);
    chk_mode(2'd0, "R8 drop mid sequence");
    unlock(8'h90);
    hv = 1'b0; wr(22'h4, 16'h0000); hv = 1'b1;
    chk_mode(2'd0, "R8 drop in identify");
    unlock(8'hA0);
    hv = 1'b0; wr(22'h3ABCDE, 16'hBEEF); hv = 1'b1;
    chk_mode(2'd0, "R8 armed write without voltage");

    // R5 single word program
    unlock(8'hA0);
    chk_mode(2'd0, "R5 armed still reads");
    exp_q.push_back({2'd0, 22'h2ABCDE, 16'hBEEF});
    tag_q.push_back("R5 program request");
    wr(22'h2ABCDE, 16'hBEEF);
    chk_mode(2'd2, "R5 busy");

    // R9 busy ignores writes
    wr(22'h0, 16'h00F0);
    chk_mode(2'd2, "R9 reset ignored while busy");
    unlock(8'h90);
    chk_mode(2'd2, "R9 identify ignored while busy");
    strobe(1'b0);
    chk_mode(2'd0, "R9 done returns read");

    // R6 multi-word and R10 fault
    exp_q.push_back({2'd1, 22'd0, 16'd0});
    tag_q.push_back("R6 multi request");
    unlock(8'h20);
    chk_mode(2'd2, "R6 busy");
    strobe(1'b1);
    chk_mode(2'd3, "R10 fault");
    wr(22'h555, 16'h00AA);
    chk_mode(2'd3, "R10 unlock ignored in fault");
    hv = 1'b0; wr(22'h0, 16'h00F0); hv = 1'b1;
    chk_mode(2'd3, "R10 reset needs voltage");
    wr(22'h0, 16'h00F0);
    chk_mode(2'd0, "R10 reset leaves fault");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 R6 R3 all results seen", 40'(exp_q.size()), 40'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule